// File: doc/BRIEF.md
# External Bus Read Controller with Ready

This block runs read cycles on an external parallel memory bus for one address zone. An internal requester raises `req_valid` with an address. The controller takes the request when it is idle, pulls the zone select low and drives the address. It counts a lead phase, then lowers the read strobe and counts an active phase. At the end of the active phase it samples a ready input. The access is stretched one cycle at a time until ready is seen high. The word on the data bus is captured at the same edge that raises the strobe. That word is returned to the requester with a one-cycle acknowledge.

The phase lengths, the use of ready and the ready mode come in as static configuration inputs. The requester changes them only while no access is in flight.

- **Synchronous mode:** ready is sampled directly at the decision edge.
- **Asynchronous mode:** ready passes through a two-flop synchronizer. Its effective sampling point on the raw pin is therefore two edges earlier.

Between accesses the address bus keeps the last address it drove.

Top module: `xbus_rd_ctrl`

## Requirements
- R1: While reset is held and after its release, `bus_cs_n` and `bus_rd_n` are 1, `req_ack` is 0 and `bus_addr` is 0.
- R2: A request is taken at a clock edge where the controller is idle and `req_valid` is 1. That edge is edge 0. From the cycle after edge 0, `bus_cs_n` is 0 and `bus_addr` equals the requested address for the whole access.
- R3: With effective lead L, cycles 0 to L-1 after edge 0 have `bus_rd_n` at 1 and cycles from L on have it at 0, until release. The strobe is never low while `bus_cs_n` is high.
- R4: A lead or active field of 0 behaves as 1, so the shortest access keeps `bus_cs_n` low for exactly 2 cycles.
- R5: With `cfg_rdy_en` at 0, every access keeps `bus_cs_n` low for exactly L+A cycles (effective values), whatever `bus_ready` does.
- R6: In synchronous mode (`cfg_rdy_async` = 0) with ready enabled, the access ends at the first edge k >= L+A at which `bus_ready` is 1 at edge k. `bus_cs_n` is low for k cycles.
- R7: In asynchronous mode (`cfg_rdy_async` = 1) with ready enabled, the decision at edge k uses the level `bus_ready` had at edge k-2. If ready rises at edge T and stays high, `bus_cs_n` is low for max(L+A, T+2) cycles.
- R8: At the ending edge k, `bus_cs_n` and `bus_rd_n` both go to 1 and `req_ack` is 1 for exactly one cycle. `req_rdata` equals the value `bus_rdata_in` had at edge k.
- R9: After an access and while idle, `bus_addr` keeps the last address driven. It changes only at the edge that starts an access.
- R10: After release, `bus_cs_n` stays 1 for at least two cycles. A request still held during the acknowledge cycle is not taken at the edge that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request, held until acknowledged |
| req_addr | input | AW | Address of the requested read |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | DW | Captured read data, valid with `req_ack` |
| cfg_lead | input | CW | Lead phase length in cycles (0 acts as 1) |
| cfg_active | input | CW | Active phase length in cycles (0 acts as 1) |
| cfg_rdy_en | input | 1 | 1: ready stretches the active phase |
| cfg_rdy_async | input | 1 | 1: ready goes through the synchronizer |
| bus_cs_n | output | 1 | Active-low zone select |
| bus_addr | output | AW | External address bus |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_rdata_in | input | DW | External read data |
| bus_ready | input | 1 | External ready |

## Verification
The assertions assume the configuration inputs stay constant from the accepting edge to release. They also assume the requester keeps `req_valid` high only until it sees the acknowledge. The bench enforces both: it changes the configuration only in idle cycles and drops the request in the acknowledge cycle or in the one after it. It drives ready as a step that rises at a chosen edge measured from edge 0, and it changes the data bus at every cycle. Together these pin down exactly which edge decides the end of the access and which data word is captured.

// File: rtl/xbus_rd_pkg.sv
package xbus_rd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LEAD   = 2'd1,
      ST_ACTIVE = 2'd2,
      ST_RECOV  = 2'd3
   } rd_state_e;

endpackage

// File: rtl/xbus_rdy_sync.sv
module xbus_rdy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rdy_raw,
   output logic rdy_sync
);
   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("xbus_rdy_sync: STAGES must be 2..4");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], rdy_raw};
   end

   assign rdy_sync = chain_q[STAGES-1];
endmodule

// File: rtl/xbus_phase_timer.sv
module xbus_phase_timer #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_lead,
   input  logic          load_active,
   input  logic [CW-1:0] cfg_lead,
   input  logic [CW-1:0] cfg_active,
   output logic          expired
);
   if (CW < 1 || CW > 8) begin : g_bad_cw
      $error("xbus_phase_timer: CW must be 1..8");
   end

   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lead_m1, act_m1;

   // a zero field is clamped to a one-cycle phase
   assign lead_m1 = (cfg_lead   == '0) ? '0 : cfg_lead   - ONE;
   assign act_m1  = (cfg_active == '0) ? '0 : cfg_active - ONE;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load_lead)      cnt_q <= lead_m1;
      else if (load_active)    cnt_q <= act_m1;
      else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
   end

   assign expired = (cnt_q == '0);

   // R4: a field of 0 or 1 yields a phase that expires in its first cycle
   a_r4_min_lead: assert property (@(posedge clk) disable iff (!rst_n)
      (load_lead && cfg_lead <= ONE) |=> expired);
   a_r4_min_active: assert property (@(posedge clk) disable iff (!rst_n)
      (load_active && !load_lead && cfg_active <= ONE) |=> expired);
endmodule

// File: rtl/xbus_rd_datapath.sv
module xbus_rd_datapath #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [AW-1:0] req_addr,
   input  logic          finish,
   input  logic [DW-1:0] bus_rdata_in,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] req_rdata,
   output logic          req_ack
);
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("xbus_rd_datapath: AW and DW must be positive");
   end

   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;
   logic          ack_q;

   // address is only reloaded when an access starts; it is never cleared
   always_ff @(posedge clk) begin
      if (!rst_n)    addr_q <= '0;
      else if (take) addr_q <= req_addr;
   end

   // data is captured on the edge that raises the read strobe
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         ack_q  <= 1'b0;
      end else begin
         ack_q <= finish;
         if (finish) data_q <= bus_rdata_in;
      end
   end

   assign bus_addr  = addr_q;
   assign req_rdata = data_q;
   assign req_ack   = ack_q;
endmodule

// File: rtl/xbus_rd_ctrl.sv
module xbus_rd_ctrl
   import xbus_rd_pkg::*;
#(
   parameter int AW          = 16,
   parameter int DW          = 16,
   parameter int CW          = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [AW-1:0] req_addr,
   output logic          req_ack,
   output logic [DW-1:0] req_rdata,
   input  logic [CW-1:0] cfg_lead,
   input  logic [CW-1:0] cfg_active,
   input  logic          cfg_rdy_en,
   input  logic          cfg_rdy_async,
   output logic          bus_cs_n,
   output logic [AW-1:0] bus_addr,
   output logic          bus_rd_n,
   input  logic [DW-1:0] bus_rdata_in,
   input  logic          bus_ready
);
   rd_state_e state_q, state_d;
   logic      cs_n_q, rd_n_q;
   logic      take, lead_done, phase_out, rdy_s, rdy_ok, finish;

   xbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .rdy_raw  (bus_ready),
      .rdy_sync (rdy_s)
   );

   xbus_phase_timer #(.CW(CW)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_lead   (take),
      .load_active (lead_done),
      .cfg_lead    (cfg_lead),
      .cfg_active  (cfg_active),
      .expired     (phase_out)
   );

   xbus_rd_datapath #(.AW(AW), .DW(DW)) u_dp (
      .clk          (clk),
      .rst_n        (rst_n),
      .take         (take),
      .req_addr     (req_addr),
      .finish       (finish),
      .bus_rdata_in (bus_rdata_in),
      .bus_addr     (bus_addr),
      .req_rdata    (req_rdata),
      .req_ack      (req_ack)
   );

   assign take      = (state_q == ST_IDLE) && req_valid;
   assign lead_done = (state_q == ST_LEAD) && phase_out;
   // async mode reads the synchronized copy, i.e. the pin as seen
   // SYNC_STAGES edges before the decision edge
   assign rdy_ok    = !cfg_rdy_en || (cfg_rdy_async ? rdy_s : bus_ready);
   assign finish    = (state_q == ST_ACTIVE) && phase_out && rdy_ok;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (take)      state_d = ST_LEAD;
         ST_LEAD:   if (lead_done) state_d = ST_ACTIVE;
         ST_ACTIVE: if (finish)    state_d = ST_RECOV;
         ST_RECOV:                 state_d = ST_IDLE;
         default:                  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cs_n_q  <= 1'b1;
         rd_n_q  <= 1'b1;
      end else begin
         state_q <= state_d;
         if (take)        cs_n_q <= 1'b0;
         else if (finish) cs_n_q <= 1'b1;
         if (lead_done)   rd_n_q <= 1'b0;
         else if (finish) rd_n_q <= 1'b1;
      end
   end

   assign bus_cs_n = cs_n_q;
   assign bus_rd_n = rd_n_q;

   // R3: strobe only inside select, and never in the first select cycle
   a_r3_rd_within_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> !bus_cs_n);
   a_r3_rd_after_lead: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_rd_n) |-> $past(!bus_cs_n));
   // R5: with ready unused the end of the active phase always releases
   a_r5_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACTIVE && phase_out && !cfg_rdy_en) |=> bus_cs_n);
   // R8: acknowledge is a single pulse coinciding with release
   a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);
   a_r8_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> ($rose(bus_cs_n) && $rose(bus_rd_n)));
   // R9: address moves only when select falls
   a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(bus_cs_n) |-> $stable(bus_addr));
   // R10: at least two high cycles after release
   a_r10_recovery: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_cs_n) |=> bus_cs_n);
endmodule

// File: tb/xbus_rd_ctrl_bench.sv
module xbus_rd_ctrl_bench;
   localparam int AW = 16;
   localparam int DW = 16;
   localparam int CW = 4;
   localparam int SYNC_DLY = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_ack;
   logic [DW-1:0] req_rdata;
   logic [CW-1:0] cfg_lead = '0;
   logic [CW-1:0] cfg_active = '0;
   logic          cfg_rdy_en = 1'b0;
   logic          cfg_rdy_async = 1'b0;
   logic          bus_cs_n;
   logic [AW-1:0] bus_addr;
   logic          bus_rd_n;
   logic [DW-1:0] bus_rdata_in = '0;
   logic          bus_ready = 1'b0;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   xbus_rd_ctrl #(.AW(AW), .DW(DW), .CW(CW), .SYNC_STAGES(SYNC_DLY)) u_xbus_rd_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ack(req_ack), .req_rdata(req_rdata), .cfg_lead(cfg_lead),
      .cfg_active(cfg_active), .cfg_rdy_en(cfg_rdy_en), .cfg_rdy_async(cfg_rdy_async),
      .bus_cs_n(bus_cs_n), .bus_addr(bus_addr), .bus_rd_n(bus_rd_n),
      .bus_rdata_in(bus_rdata_in), .bus_ready(bus_ready)
   );

   function automatic int eff(int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int exp_end(int l, int a, bit en, bit asy, int tr);
      int base = eff(l) + eff(a);
      int t = asy ? tr + SYNC_DLY : tr;
      if (!en) return base;
      return (t > base) ? t : base;
   endfunction

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_access(int l, int a, bit en, bit asy, int tr, bit hold,
                             logic [AW-1:0] adr, logic [DW-1:0] dbase);
      int e = exp_end(l, a, en, asy, tr);
      string tag = !en ? "R5" : (asy ? "R7" : "R6");
      cfg_lead      = CW'(l);
      cfg_active    = CW'(a);
      cfg_rdy_en    = en;
      cfg_rdy_async = asy;
      req_valid     = 1'b1;
      req_addr      = adr;
      bus_ready     = (tr <= 0);
      bus_rdata_in  = dbase;
      for (int n = 0; n <= 400; n++) begin
         @(negedge clk);
         if (n < e) begin
            chk(bus_cs_n == 1'b0, tag, "cs_n low during access", bus_cs_n, 0);
            chk(bus_addr == adr, "R2", "address during access", bus_addr, adr);
            chk(bus_rd_n == (n < eff(l)), "R3", "strobe phase", bus_rd_n, (n < eff(l)));
            chk(req_ack == 1'b0, "R8", "no early ack", req_ack, 0);
            bus_ready    = (n + 1 >= tr);
            bus_rdata_in = dbase ^ DW'(n + 1);
         end else begin
            chk(bus_cs_n == 1'b1, tag, "release edge", bus_cs_n, 1);
            chk(bus_rd_n == 1'b1, "R8", "strobe released", bus_rd_n, 1);
            chk(req_ack == 1'b1, "R8", "ack pulse", req_ack, 1);
            chk(req_rdata == (dbase ^ DW'(e)), "R8", "captured data", req_rdata, dbase ^ DW'(e));
            chk(bus_addr == adr, "R9", "address held at release", bus_addr, adr);
            break;
         end
      end
      bus_ready    = 1'b0;
      bus_rdata_in = ~dbase;
      if (hold) begin
         @(negedge clk);
         chk(bus_cs_n == 1'b1, "R10", "held request not retaken", bus_cs_n, 1);
         chk(req_ack == 1'b0, "R8", "ack single cycle", req_ack, 1'b0);
         req_valid = 1'b0;
      end else begin
         req_valid = 1'b0;
         @(negedge clk);
         chk(bus_cs_n == 1'b1, "R10", "recovery cycle", bus_cs_n, 1);
      end
      bus_ready = 1'b1;
      @(negedge clk);
      chk(bus_cs_n == 1'b1 && bus_rd_n == 1'b1, "R10", "idle select", bus_cs_n, 1);
      chk(bus_addr == adr, "R9", "address held in idle", bus_addr, adr);
      bus_ready = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL R2 watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20041));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(bus_cs_n == 1'b1 && bus_rd_n == 1'b1, "R1", "strobes in reset", {bus_cs_n, bus_rd_n}, 3);
      chk(req_ack == 1'b0 && bus_addr == '0, "R1", "ack/address in reset", bus_addr, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_cs_n == 1'b1 && req_ack == 1'b0, "R1", "state after release", bus_cs_n, 1);

      // directed corners
      run_access(1, 1, 1'b1, 1'b0, 0, 1'b0, 16'h1234, 16'h0A00);   // R6 minimum, ready already high
      run_access(0, 0, 1'b1, 1'b0, 0, 1'b0, 16'h2001, 16'h0B00);   // R4 zero fields act as one
      run_access(0, 3, 1'b0, 1'b0, 999, 1'b0, 16'h2002, 16'h0C00); // R4 zero lead only
      run_access(3, 4, 1'b0, 1'b0, 999, 1'b0, 16'h3003, 16'h0D00); // R5 ready ignored
      run_access(3, 4, 1'b0, 1'b1, 999, 1'b1, 16'h3004, 16'h0E00); // R5 async ignored, R10 held req
      run_access(2, 3, 1'b1, 1'b0, 12, 1'b0, 16'h4005, 16'h0F00);  // R6 stretched to 12
      run_access(2, 3, 1'b1, 1'b1, 12, 1'b0, 16'h4006, 16'h1100);  // R7 stretched to 14
      run_access(1, 1, 1'b1, 1'b1, 0, 1'b0, 16'h5007, 16'h1200);   // R7 ready early: 2
      run_access(1, 1, 1'b1, 1'b1, 1, 1'b1, 16'h5008, 16'h1300);   // R7 two-edge offset: 3
      run_access(1, 1, 1'b1, 1'b0, 1, 1'b0, 16'h5009, 16'h1400);   // R6 same step: 2
      run_access(15, 15, 1'b1, 1'b0, 5, 1'b0, 16'hFFFF, 16'h1500); // R3 longest phases

      // constrained random
      for (int i = 0; i < 80; i++) begin
         int l   = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 15)) : int'($urandom_range(0, 5));
         int a   = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 15)) : int'($urandom_range(0, 5));
         bit en  = ($urandom_range(0, 3) != 0);
         bit asy = $urandom_range(0, 1) == 1;
         int tr  = en ? int'($urandom_range(0, 20)) : 999;
         bit hld = $urandom_range(0, 1) == 1;
         run_access(l, a, en, asy, tr, hld, AW'($urandom), DW'($urandom));
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule